// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the software-facing register bank of a four-channel DMA controller with a byte-wide data port. It decodes a 16-entry I/O offset space. Through that space the host programs a 16-bit start address and a 16-bit transfer count per channel. The host also sets each channel's operating mode, masks or unmasks channels, raises software requests and writes a command byte. It can read a status byte back.

Each 16-bit register is reached through a single byte-wide offset. One pointer flip-flop, shared by all channels, decides whether an access touches the low byte or the high byte. Every address or count access advances that pointer. Software returns it to the low-byte state by writing to a dedicated offset.

Mask and mode writes carry the target channel number in bits [1:0] of the data byte. This is why a single offset serves all four channels. The programmed values are presented on flat output buses to the transfer engine, which lies outside this block.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the command byte is 0x00, the request bits are 0, every mode field is 0, every address and count is 0, and the byte pointer selects the low byte.
- R2: Offset 2*ch holds channel ch's address. A write stores the data byte into the low byte (pointer low) or the high byte (pointer high) of both the base and the current copy. A read returns the byte of the current copy that the pointer selects. `addr_o` bits [16*ch+15:16*ch] show the base address.
- R3: Offset 2*ch+1 holds channel ch's count, with the same byte behaviour as R2. `cnt_o` bits [16*ch+15:16*ch] show the base count.
- R4: Each accepted read or write at offsets 0x0 to 0x7 toggles the byte pointer after the access. The pointer is shared by every channel and by both address and count registers.
- R5: Any write to offset 0xC returns the byte pointer to the low-byte state.
- R6: A write to offset 0xA selects channel data[1:0]. It sets that channel's mask bit when data[2]=1 and clears it when data[2]=0.
- R7: A write to offset 0xB stores data[7:2] as the mode of channel data[1:0]. The mode appears on `mode_o` bits [6*ch+5:6*ch].
- R8: A write to offset 0x8 loads the command byte shown on `cmd_o`. A read at offset 0x8 returns status instead: the request bits in [7:4] (channel n in bit 4+n) and zeros in [3:0].
- R9: A write to offset 0x9 sets the request bit of channel data[1:0] when data[2]=1 and clears it when data[2]=0. The request bits appear on `req_o`.
- R10: A write to offset 0xD clears the command byte, the request bits and the byte pointer, sets all mask bits, and leaves modes, addresses and counts unchanged. A read at 0xD returns 0x00.
- R11: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask bits from data[3:0].
- R12: While `sel` is 0, `wr_en` and `rd_en` have no effect on any register or on the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select that qualifies accesses |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (advances the byte pointer on address/count reads) |
| offs | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| mode_o | output | 24 | Six mode bits per channel |
| mask_o | output | 4 | Mask bit per channel (1 = disabled) |
| req_o | output | 4 | Software request bit per channel |
| cmd_o | output | 8 | Command byte |
| addr_o | output | 64 | Base address per channel |
| cnt_o | output | 64 | Base count per channel |

## Verification
The hardest condition to reach from the ports is a byte pointer left in the high state by an access to a different channel or register kind. In that state the next access lands on an unexpected byte. The stimulus table creates this on purpose. It writes one low byte to a channel-2 address and then reads a channel-3 count, which must return the high byte. Master clear is then issued with the pointer high, and a later read must come back from the low byte.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        offs,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH*6-1:0]  mode_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH*2*DW-1:0] addr_o,
  output logic [NCH*2*DW-1:0] cnt_o
);
  localparam int RW  = 2 * DW;
  localparam int CHW = $clog2(NCH);

  logic [RW-1:0]  base_q [NCH][2];
  logic [RW-1:0]  cur_q  [NCH][2];
  logic [5:0]     mode_q [NCH];
  logic [NCH-1:0] mask_q, req_q;
  logic [DW-1:0]  cmd_q;
  logic           ff_q;

  wire            wr      = sel & wr_en;
  wire            rd      = sel & rd_en;
  wire            is_rc   = ~offs[3];
  wire [CHW-1:0]  rc_ch   = offs[CHW:1];
  wire            rc_kind = offs[0];
  wire [CHW-1:0]  d_ch    = wdata[CHW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < 2; k++) begin
          base_q[c][k] <= '0;
          cur_q[c][k]  <= '0;
        end
        mode_q[c] <= '0;
      end
      mask_q <= '1;
      req_q  <= '0;
      cmd_q  <= '0;
      ff_q   <= 1'b0;
    end else begin
      if ((wr | rd) && is_rc) ff_q <= ~ff_q;
      if (wr) begin
        if (is_rc) begin
          if (ff_q) begin
            base_q[rc_ch][rc_kind][RW-1:DW] <= wdata;
            cur_q[rc_ch][rc_kind][RW-1:DW]  <= wdata;
          end else begin
            base_q[rc_ch][rc_kind][DW-1:0] <= wdata;
            cur_q[rc_ch][rc_kind][DW-1:0]  <= wdata;
          end
        end else begin
          case (offs[2:0])
            3'd0: cmd_q <= wdata;
            3'd1: req_q[d_ch] <= wdata[2];
            3'd2: mask_q[d_ch] <= wdata[2];
            3'd3: mode_q[d_ch] <= wdata[7:2];
            3'd4: ff_q <= 1'b0;
            3'd5: begin
              cmd_q  <= '0;
              req_q  <= '0;
              mask_q <= '1;
              ff_q   <= 1'b0;
            end
            3'd6: mask_q <= '0;
            3'd7: mask_q <= wdata[NCH-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_rc)
      rdata = ff_q ? cur_q[rc_ch][rc_kind][RW-1:DW] : cur_q[rc_ch][rc_kind][DW-1:0];
    else if (offs[2:0] == 3'd0)
      rdata = {req_q, 4'b0000};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign mode_o[6*c +: 6]  = mode_q[c];
    assign addr_o[RW*c +: RW] = base_q[c][0];
    assign cnt_o[RW*c +: RW]  = base_q[c][1];
  end
  assign mask_o = mask_q;
  assign req_o  = req_q;
  assign cmd_o  = cmd_q;

  // R4: pointer toggles on every address/count access
  a_r4_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (wr_en || rd_en) && !offs[3]) |=> (ff_q != $past(ff_q)));

  // R5: clear-pointer write lands on low byte
  a_r5_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && offs == 4'hC) |=> !ff_q);

  // R6: single mask write
  a_r6_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && offs == 4'hA) |=> (mask_o[$past(wdata[1:0])] == $past(wdata[2])));

  // R10: master clear
  a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && offs == 4'hD) |=> (mask_o == '1 && cmd_o == '0 && req_o == '0 && !ff_q));

  // R11: clear-mask command
  a_r11_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && offs == 4'hE) |=> (mask_o == '0));

  // R12: deselected strobes change nothing
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(mask_o) && $stable(cmd_o) && $stable(req_o) && $stable(ff_q) && $stable(mode_o)));
endmodule

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;
  logic        clk = 0, rst_n = 0, sel = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  offs = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] mode_o;
  logic [3:0]  mask_o, req_o;
  logic [7:0]  cmd_o;
  logic [63:0] addr_o, cnt_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_regfile dut_i (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .offs(offs), .wdata(wdata), .rdata(rdata), .mode_o(mode_o), .mask_o(mask_o),
    .req_o(req_o), .cmd_o(cmd_o), .addr_o(addr_o), .cnt_o(cnt_o));

  // {is_read, offset, write data, expected read data}
  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'hC, 8'h00, 8'h00},
    {1'b0, 4'h0, 8'h34, 8'h00},
    {1'b0, 4'h0, 8'h12, 8'h00},
    {1'b0, 4'h3, 8'hCD, 8'h00},
    {1'b0, 4'h3, 8'hAB, 8'h00},
    {1'b1, 4'h0, 8'h00, 8'h34},  // R2
    {1'b1, 4'h0, 8'h00, 8'h12},  // R2
    {1'b1, 4'h3, 8'h00, 8'hCD},  // R3
    {1'b1, 4'h3, 8'h00, 8'hAB},  // R3
    {1'b0, 4'h4, 8'h77, 8'h00},
    {1'b1, 4'h7, 8'h00, 8'h00},  // R4 shared pointer -> high byte
    {1'b1, 4'h4, 8'h00, 8'h77},  // R4
    {1'b0, 4'hC, 8'h00, 8'h00},
    {1'b1, 4'h4, 8'h00, 8'h77},  // R5
    {1'b0, 4'h9, 8'h06, 8'h00},
    {1'b1, 4'h8, 8'h00, 8'h40},  // R8 status
    {1'b0, 4'h8, 8'hA5, 8'h00},
    {1'b1, 4'h8, 8'h00, 8'h40},  // R8 status not command
    {1'b1, 4'hD, 8'h00, 8'h00},  // R10 temp read
    {1'b1, 4'h4, 8'h00, 8'h00},  // R4 high byte
    {1'b1, 4'h4, 8'h00, 8'h77}   // R4 low byte
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; offs = o; wdata = d;
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] o, output logic [7:0] d);
    @(negedge clk); sel = 1; rd_en = 1; offs = o;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 mask", mask_o, 4'hF);
    check("R1 cmd", cmd_o, 8'h00);
    check("R1 req", req_o, 4'h0);
    check("R1 mode", mode_o, 24'h0);
    check("R1 addr", addr_o, 64'h0);
    rst_n = 1;
    rd(4'h0, d); check("R1 pointer low", d, 8'h00);
    wr(4'hC, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], d);
        check($sformatf("R2/R3/R4/R5/R8 vector %0d", i), d, VEC[i][7:0]);
      end else wr(VEC[i][19:16], VEC[i][15:8]);
    end

    check("R2 addr_o ch0", addr_o[15:0], 16'h1234);
    check("R3 cnt_o ch1", cnt_o[31:16], 16'hABCD);
    check("R8 cmd_o", cmd_o, 8'hA5);
    check("R9 req set", req_o, 4'h4);
    wr(4'h9, 8'h05); check("R9 req ch1", req_o, 4'h6);
    wr(4'h9, 8'h02); check("R9 req clear", req_o, 4'h2);

    wr(4'hA, 8'h01); check("R6 unmask ch1", mask_o, 4'hD);
    wr(4'hA, 8'h05); check("R6 mask ch1", mask_o, 4'hF);
    wr(4'hE, 8'h00); check("R11 clear mask", mask_o, 4'h0);
    wr(4'hF, 8'h0A); check("R11 all mask", mask_o, 4'hA);

    wr(4'hB, 8'h56); check("R7 mode ch2", mode_o[17:12], 6'h15);
    wr(4'hB, 8'hC1); check("R7 mode ch1", mode_o[11:6], 6'h30);
    check("R7 mode ch0 untouched", mode_o[5:0], 6'h00);

    @(negedge clk); wr_en = 1; offs = 4'hD; wdata = 8'h00;
    @(negedge clk); wr_en = 0;
    check("R12 ignored mask", mask_o, 4'hA);
    check("R12 ignored cmd", cmd_o, 8'hA5);
    wr(4'hC, 8'h00);
    @(negedge clk); rd_en = 1; offs = 4'h0;
    @(negedge clk); rd_en = 0;
    rd(4'h0, d); check("R12 pointer kept low", d, 8'h34);

    wr(4'hD, 8'h00);
    check("R10 mask", mask_o, 4'hF);
    check("R10 cmd", cmd_o, 8'h00);
    check("R10 req", req_o, 4'h0);
    check("R10 mode kept", mode_o[17:12], 6'h15);
    check("R10 addr kept", addr_o[15:0], 16'h1234);
    rd(4'h0, d); check("R10 pointer low", d, 8'h34);

    done = 1;
    finish_run();
  end
endmodule